// File: doc/BRIEF.md
# Floppy Controller Command and Result Phase Engine

This block sequences the byte-wide command, execution and result phases of a PC-style floppy disk controller. The host writes one or two command bytes into a data register. The engine decodes the opcode and runs a short execution phase. It then loads one to seven result bytes, which the host reads back through the same data register. Once every result byte has been read, the engine returns to command phase. A main status register tells the host when it may transfer a byte and in which direction.

A control register carries a software reset bit. While that bit is low the engine is held in reset and ignores every other register write. Raising the bit again restarts the engine and raises the interrupt output. Per-drive write-protect and track-zero levels come in on input pins. A head flag for each drive is kept internally, so status bytes can report it. No media transfer takes place: read-ID only waits out a fixed execution time and reports a fixed sector address.

Top module: `flop_cmd_engine`

## Requirements
- R1: Register addresses are 0 for control, 1 for main status and 2 for data. After hardware reset the status reads 0x80, the control register reads 0x04, the interrupt output is low and a data read returns 0x00.
- R2: Writing the control register with bit 2 clear enters soft reset. The status then reads 0x00, the control register reads the written value, data writes are ignored and data reads return 0x00.
- R3: In soft reset, a control write with bit 2 clear is ignored and the control register keeps its value. A control write with bit 2 set leaves reset. It selects drive 0, returns to command phase at position 0 (status 0x80) and raises the interrupt output.
- R4: Version (opcode 0x10) is one byte and returns the single byte 0x90.
- R5: Sense drive status (opcode 0x04) takes a second byte. Bits 1:0 of that byte select the drive and bit 2 sets that drive's head flag. The reply is one byte: write-protect in bit 6, track-zero in bit 4, the constant 0x28, the head in bit 2 and the drive in bits 1:0.
- R6: Sense interrupt (opcode 0x08) is one byte. It returns three bytes: 0x60 ORed with the current head shifted left by 2 and the current drive, then 0x00 and 0x00. The interrupt output falls when the result is loaded.
- R7: Read-ID (opcode 0x0A) takes a second byte, decoded for drive and head as in R5. It stays in execution for EXEC_CYCLES cycles with status 0x10. It then raises the interrupt output and returns seven bytes: head<<2|drive, 0x00, 0x00, 0x00, head, 0x01, 0x02.
- R8: Any other opcode returns the single byte 0x80.
- R9: Only bits 4:0 of the first command byte select the command; bits 7:5 are ignored.
- R10: The status register has ready-for-transfer in bit 7, host-read direction in bit 6 and busy in bit 4. It reads 0x80 when idle, 0x90 between command bytes, 0x10 during execution and 0xD0 in result phase.
- R11: The result phase ends when the number of bytes read reaches the result length, and the status then reads 0x80. Data writes during the result phase are ignored. Data reads outside the result phase return 0x00 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops a result byte) |
| regAddr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from regAddr |
| wpIn | input | NUM_DRIVES | Write-protect level per drive |
| trk0In | input | NUM_DRIVES | Track-zero level per drive |
| irqOut | output | 1 | Interrupt request level |

## Verification
The command table covers each opcode and several drive/head pairs. The pairs are chosen so that the write-protect, track-zero, head and drive fields take different values and any misplaced bit stands out. Opcodes with the upper bits set tell a full-byte decode apart from a 5-bit decode. Read-ID followed by sense interrupt shows the head flag carried from one command to the next, and the interrupt being set and then cleared. Directed sequences check the following:
- the status value mid-command and during execution
- data writes made during the result phase
- data reads made in command phase
- the full soft-reset entry, hold and exit sequence, showing that writes made while held change nothing.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int FIFO_DEPTH = 8;
  localparam int IDX_W = $clog2(FIFO_DEPTH);
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_t;
  typedef enum logic [2:0] {K_VER, K_SDS, K_SINT, K_RID, K_BAD} cmd_t;

  typedef struct packed {
    logic ctlLoad;
    logic softReset;
    logic selLoad;
    logic resLoad;
    cmd_t resKind;
  } strobe_t;

  function automatic cmd_t decodeOp(logic [4:0] op);
    case (op)
      5'h10:   return K_VER;
      5'h04:   return K_SDS;
      5'h08:   return K_SINT;
      5'h0A:   return K_RID;
      default: return K_BAD;
    endcase
  endfunction

  function automatic logic needsSecond(cmd_t k);
    return (k == K_SDS) || (k == K_RID);
  endfunction

  function automatic logic [IDX_W:0] resBytes(cmd_t k);
    case (k)
      K_SINT:  return (IDX_W+1)'(3);
      K_RID:   return (IDX_W+1)'(7);
      default: return (IDX_W+1)'(1);
    endcase
  endfunction
endpackage

// File: rtl/fce_ctrl.sv
module fce_ctrl
  import fce_pkg::*;
#(
  parameter int EXEC_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [4:0]        opBits,
  output strobe_t           stb,
  output phase_t            phase,
  output logic              inRst,
  output logic [IDX_W-1:0]  pos,
  output logic [IDX_W:0]    resLen,
  output logic [7:0]        msr
);
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1);
  localparam logic [IDX_W:0] ONE = 1;

  logic [CNT_W-1:0] execCnt;
  cmd_t kind;
  logic ctlWr, dataWr, dataRd;

  assign ctlWr  = regWr && (regAddr == ADDR_CTL);
  assign dataWr = regWr && (regAddr == ADDR_DATA) && !inRst;
  assign dataRd = regRd && (regAddr == ADDR_DATA) && !inRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_CMD;
      pos     <= '0;
      kind    <= K_VER;
      execCnt <= '0;
      inRst   <= 1'b0;
      resLen  <= '0;
    end else if (ctlWr) begin
      if (!opBits[2]) begin
        inRst <= 1'b1;
      end else if (inRst) begin
        inRst <= 1'b0;
        phase <= PH_CMD;
        pos   <= '0;
      end
    end else if (!inRst) begin
      case (phase)
        PH_CMD: if (dataWr) begin
          if (pos == '0) begin
            kind <= decodeOp(opBits);
            if (needsSecond(decodeOp(opBits))) begin
              pos <= IDX_W'(1);
            end else begin
              phase   <= PH_EXEC;
              execCnt <= '0;
            end
          end else begin
            phase   <= PH_EXEC;
            pos     <= '0;
            execCnt <= (kind == K_RID) ? CNT_W'(EXEC_CYCLES - 1) : '0;
          end
        end
        PH_EXEC: begin
          if (execCnt == '0) begin
            phase  <= PH_RES;
            pos    <= '0;
            resLen <= resBytes(kind);
          end else begin
            execCnt <= execCnt - 1'b1;
          end
        end
        PH_RES: if (dataRd) begin
          if (({1'b0, pos} + ONE) == resLen) begin
            pos   <= '0;
            phase <= PH_CMD;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: phase <= PH_CMD;
      endcase
    end
  end

  always_comb begin
    stb.ctlLoad   = ctlWr && (!inRst || opBits[2]);
    stb.softReset = ctlWr && inRst && opBits[2];
    stb.selLoad   = dataWr && (phase == PH_CMD) && (pos != '0);
    stb.resLoad   = !inRst && !ctlWr && (phase == PH_EXEC) && (execCnt == '0);
    stb.resKind   = kind;
  end

  always_comb begin
    if (inRst) msr = 8'h00;
    else begin
      case (phase)
        PH_CMD:  msr = (pos == '0) ? 8'h80 : 8'h90;
        PH_EXEC: msr = 8'h10;
        PH_RES:  msr = 8'hD0;
        default: msr = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/fce_datapath.sv
module fce_datapath
  import fce_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [7:0]            wrData,
  input  logic [ADDR_W-1:0]     regAddr,
  input  phase_t                phase,
  input  logic                  inRst,
  input  logic [IDX_W-1:0]      pos,
  input  logic [7:0]            msr,
  input  logic [NUM_DRIVES-1:0] wpIn,
  input  logic [NUM_DRIVES-1:0] trk0In,
  output logic [7:0]            rdData,
  output logic                  irqOut
);
  localparam int DRV_W = $clog2(NUM_DRIVES);

  logic [7:0]            ctlReg;
  logic [DRV_W-1:0]      curDrv;
  logic [NUM_DRIVES-1:0] headBits;
  logic [7:0]            resBuf [FIFO_DEPTH];
  logic [7:0]            hdDrv;

  assign hdDrv = (8'(headBits[curDrv]) << 2) | 8'(curDrv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg   <= 8'h04;
      curDrv   <= '0;
      headBits <= '0;
      irqOut   <= 1'b0;
      for (int i = 0; i < FIFO_DEPTH; i++) resBuf[i] <= '0;
    end else begin
      if (stb.ctlLoad) ctlReg <= wrData;
      if (stb.softReset) begin
        curDrv <= '0;
        irqOut <= 1'b1;
      end
      if (stb.selLoad) begin
        curDrv <= wrData[DRV_W-1:0];
        headBits[wrData[DRV_W-1:0]] <= wrData[2];
      end
      if (stb.resLoad) begin
        case (stb.resKind)
          K_VER: resBuf[0] <= 8'h90;
          K_SDS: resBuf[0] <= (8'(wpIn[curDrv]) << 6) | (8'(trk0In[curDrv]) << 4)
                              | 8'h28 | hdDrv;
          K_SINT: begin
            resBuf[0] <= 8'h60 | hdDrv;
            resBuf[1] <= 8'h00;
            resBuf[2] <= 8'h00;
            irqOut    <= 1'b0;
          end
          K_RID: begin
            resBuf[0] <= hdDrv;
            resBuf[1] <= 8'h00;
            resBuf[2] <= 8'h00;
            resBuf[3] <= 8'h00;
            resBuf[4] <= 8'(headBits[curDrv]);
            resBuf[5] <= 8'h01;
            resBuf[6] <= 8'h02;
            irqOut    <= 1'b1;
          end
          default: resBuf[0] <= 8'h80;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTL:  rdData = ctlReg;
      ADDR_STAT: rdData = msr;
      ADDR_DATA: rdData = (!inRst && phase == PH_RES) ? resBuf[pos] : 8'h00;
      default:   rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/flop_cmd_engine.sv
module flop_cmd_engine
  import fce_pkg::*;
#(
  parameter int NUM_DRIVES  = 4,
  parameter int EXEC_CYCLES = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [1:0]            regAddr,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  input  logic [NUM_DRIVES-1:0] wpIn,
  input  logic [NUM_DRIVES-1:0] trk0In,
  output logic                  irqOut
);
  strobe_t          stb;
  phase_t           phase;
  logic             inRst;
  logic [IDX_W-1:0] pos;
  logic [IDX_W:0]   resLen;
  logic [7:0]       msr;

  fce_ctrl #(.EXEC_CYCLES(EXEC_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .opBits(wrData[4:0]), .stb(stb), .phase(phase), .inRst(inRst), .pos(pos),
    .resLen(resLen), .msr(msr)
  );

  fce_datapath #(.NUM_DRIVES(NUM_DRIVES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .regAddr(regAddr),
    .phase(phase), .inRst(inRst), .pos(pos), .msr(msr), .wpIn(wpIn),
    .trk0In(trk0In), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/flop_cmd_engine_chk.sv
module flop_cmd_engine_chk
  import fce_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic             regRd,
  input logic [1:0]       regAddr,
  input logic [7:0]       wrData,
  input logic             inRst,
  input phase_t           phase,
  input logic [IDX_W-1:0] pos,
  input logic [IDX_W:0]   resLen,
  input logic             irqOut
);
  localparam logic [IDX_W:0] ONE = 1;

  // R2
  enter_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inRst && regWr && regAddr == ADDR_CTL && !wrData[2]) |=> inRst);

  // R3
  stay_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRst && regWr && regAddr == ADDR_CTL && !wrData[2]) |=> inRst);

  // R3
  leave_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRst && regWr && regAddr == ADDR_CTL && wrData[2])
      |=> (!inRst && phase == PH_CMD && pos == '0 && irqOut));

  // R2
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRst && !(regWr && regAddr == ADDR_CTL)) |=> ($stable(phase) && $stable(pos)));

  // R11
  res_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RES) |-> ({1'b0, pos} < resLen));

  // R11
  last_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inRst && phase == PH_RES && regRd && !regWr && regAddr == ADDR_DATA
      && ({1'b0, pos} + ONE) == resLen) |=> (phase == PH_CMD));
endmodule

bind flop_cmd_engine flop_cmd_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .wrData(wrData), .inRst(inRst), .phase(phase), .pos(pos), .resLen(resLen),
  .irqOut(irqOut)
);

// File: tb/flop_cmd_engine_bench.sv
module flop_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EXEC = 20;
  localparam logic [1:0] A_CTL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
  localparam int NV = 11;
  // fields: nCmd[77:76] cmd0[75:68] cmd1[67:60] nRes[59:56] res bytes[55:0]
  // drive inputs: wpIn=4'b0101, trk0In=4'b0011
  localparam logic [77:0] VECS [NV] = '{
    {2'd1, 8'h10, 8'h00, 4'd1, 8'h90, 48'h0},               // R4
    {2'd1, 8'hF0, 8'h00, 4'd1, 8'h90, 48'h0},               // R9
    {2'd2, 8'h04, 8'h00, 4'd1, 8'h78, 48'h0},               // R5
    {2'd2, 8'h04, 8'h06, 4'd1, 8'h6E, 48'h0},               // R5
    {2'd2, 8'hC4, 8'h05, 4'd1, 8'h3D, 48'h0},               // R5 R9
    {2'd1, 8'h08, 8'h00, 4'd3, 24'h650000, 32'h0},          // R6
    {2'd2, 8'h0A, 8'h03, 4'd7, 56'h03_00_00_00_00_01_02},   // R7
    {2'd1, 8'h08, 8'h00, 4'd3, 24'h630000, 32'h0},          // R6
    {2'd1, 8'h1F, 8'h00, 4'd1, 8'h80, 48'h0},               // R8
    {2'd2, 8'h4A, 8'h07, 4'd7, 56'h07_00_00_00_01_01_02},   // R7 R9
    {2'd2, 8'h04, 8'h03, 4'd1, 8'h2B, 48'h0}                // R5
  };

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [3:0] wpIn = 4'b0101, trk0In = 4'b0011;
  logic irqOut;
  int total = 0, bad = 0, cycles = 0;
  logic [7:0] v;

  flop_cmd_engine #(.NUM_DRIVES(4), .EXEC_CYCLES(EXEC)) u_flop_cmd_engine (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .wpIn(wpIn), .trk0In(trk0In), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; wrData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = rdData;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); regAddr = A_DATA; regRd = 1'b1; #1 d = rdData;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 200; i++) begin
      peek(A_STAT, v);
      if (v[7]) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    peek(A_STAT, v); check("R1 status", v, 8'h80);
    peek(A_CTL, v);  check("R1 control", v, 8'h04);
    check("R1 irq", {7'b0, irqOut}, 8'h00);
    peek(A_DATA, v); check("R1 data", v, 8'h00);

    // table walk
    for (int n = 0; n < NV; n++) begin
      logic [77:0] e;
      e = VECS[n];
      wr(A_DATA, e[75:68]);
      if (e[77:76] == 2'd2) wr(A_DATA, e[67:60]);
      waitReady();
      peek(A_STAT, v); check("R10 result status", v, 8'hD0);
      for (int b = 0; b < int'(e[59:56]); b++) begin
        pop(v);
        check($sformatf("R4-8 vec%0d byte%0d", n, b), v, e[55-8*b -: 8]);
      end
      peek(A_STAT, v); check("R11 back to idle", v, 8'h80);
    end

    // R10 mid-command and R7 execution timing / irq
    wr(A_DATA, 8'h0A);
    peek(A_STAT, v); check("R10 mid-command", v, 8'h90);
    wr(A_DATA, 8'h01);
    peek(A_STAT, v); check("R7 exec busy", v, 8'h10);
    repeat (EXEC - 4) @(negedge clk);
    peek(A_STAT, v); check("R7 still executing", v, 8'h10);
    waitReady();
    check("R7 irq raised", {7'b0, irqOut}, 8'h01);
    for (int b = 0; b < 7; b++) pop(v);
    wr(A_DATA, 8'h08);
    waitReady();
    check("R6 irq cleared", {7'b0, irqOut}, 8'h00);
    pop(v); check("R6 st0 drive1 head0", v, 8'h61);
    pop(v); pop(v);

    // R11 write during result ignored, read in command phase harmless
    wr(A_DATA, 8'h10);
    waitReady();
    wr(A_DATA, 8'h04);
    pop(v); check("R11 result kept", v, 8'h90);
    peek(A_STAT, v); check("R11 idle after", v, 8'h80);
    pop(v); check("R11 idle data read", v, 8'h00);
    peek(A_STAT, v); check("R11 idle unchanged", v, 8'h80);

    // R2 / R3 soft reset
    wr(A_DATA, 8'h04);
    wr(A_CTL, 8'h00);
    peek(A_STAT, v); check("R2 status in reset", v, 8'h00);
    peek(A_CTL, v);  check("R2 control value", v, 8'h00);
    wr(A_DATA, 8'h10);
    pop(v); check("R2 data read in reset", v, 8'h00);
    wr(A_CTL, 8'h08);
    peek(A_CTL, v);  check("R3 control write ignored", v, 8'h00);
    peek(A_STAT, v); check("R3 still in reset", v, 8'h00);
    wr(A_CTL, 8'h04);
    peek(A_STAT, v); check("R3 idle after exit", v, 8'h80);
    check("R3 irq on exit", {7'b0, irqOut}, 8'h01);
    peek(A_CTL, v);  check("R3 control value", v, 8'h04);
    wr(A_DATA, 8'h08);
    waitReady();
    pop(v); check("R3 drive reset to 0", v, 8'h60);
    pop(v); pop(v);
    peek(A_STAT, v); check("R11 idle end", v, 8'h80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule